// File: doc/BRIEF.md
# Windowed Watchdog Timer with Two-Byte Service Key

This block is a watchdog counter that asks for a system reset when software stops servicing it. Software picks, once after reset, a timeout length, the count source and whether window mode is on. The count source is either every system clock, or a single-cycle enable pulse that stands in for a slow low-power tick. Software services the watchdog by writing a two-byte key into a byte-wide service port. A correct key restarts the count from zero.

When window mode is on and the fast source is selected, service writes are only allowed in the last quarter of the period. A write that arrives earlier is treated as a fault and raises the reset request. The reset request is a registered, single-cycle pulse. Timeout lengths are powers of two set by parameters: three per source, picked by a 2-bit select. Select 00 turns the watchdog off.

Top module: `wdog_window_top`

## Requirements
- R1: Out of reset `rst_req` is 0 and the configuration is timeout select 11, slow source, window off, so the watchdog is already counting slow ticks.
- R2: With timeout select 00 the counter is off. `rst_req` stays 0, and service writes have no effect, even with window mode requested.
- R3: With `cfg_fast_src`=0 the counter advances only in cycles where `slow_tick` is 1. Selects 01/10/11 give timeouts of 2^SLOW_EXP1/2/3 ticks.
- R4: With `cfg_fast_src`=1 the counter advances every clock. Selects 01/10/11 give timeouts of 2^FAST_EXP1/2/3 cycles.
- R5: When the count reaches the timeout without a service, `rst_req` is 1 for exactly the one cycle after the edge that completes the period. The count then restarts from zero.
- R6: The first `cfg_we` after reset loads `cfg_timeout_sel`, `cfg_fast_src` and `cfg_window_en` and restarts the count. Every later `cfg_we` is ignored.
- R7: A service write of 0x55 followed directly by a service write of 0xAA restarts the count from zero, and no reset request results.
- R8: If a 0x55 is followed by any service value other than 0xAA, the partial key is dropped. A later 0xAA without a fresh 0x55 does not clear the count.
- R9: With window mode on and the fast source selected, a service write seen while the count is below 3/4 of the timeout raises `rst_req` on the next cycle and restarts the count.
- R10: With window mode on and the fast source selected, service writes at a count of 3/4 of the timeout or more are accepted, and a full key clears the count.
- R11: With the slow source selected, the window bit has no effect, and a key is accepted at any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable standing in for the slow low-power tick |
| cfg_we | input | 1 | Configuration write strobe (honoured once) |
| cfg_timeout_sel | input | 2 | Timeout select: 00 off, 01/10/11 short/medium/long |
| cfg_fast_src | input | 1 | Source select: 0 slow tick, 1 every clock |
| cfg_window_en | input | 1 | Window mode enable |
| svc_we | input | 1 | Service port write strobe |
| svc_data | input | 8 | Service byte |
| rst_req | output | 1 | Registered one-cycle reset request |

## Verification
Every effect appears one edge after its stimulus. A configuration write, a service byte or a counted tick lands at the edge where it is presented. `rst_req` is a register, so it rises in the cycle after the edge at which the period completes or an early write is seen. The bench drives and samples at falling edges and counts the rising edges between stimulus and check. It therefore expects a timeout exactly 2^E counted edges after the last restart, and an early-write pulse immediately after the offending write. It probes one count below and one count at the window threshold, and one edge before and at each deadline.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

  typedef struct packed {
    logic [1:0] tsel;
    logic       fast;
    logic       win;
  } wd_cfg_t;

  localparam logic [1:0] TSEL_OFF  = 2'b00;
  localparam logic [7:0] KEY_FIRST = 8'h55;
  localparam logic [7:0] KEY_LAST  = 8'hAA;

  localparam wd_cfg_t CFG_RESET = '{tsel: 2'b11, fast: 1'b0, win: 1'b0};

endpackage

// File: rtl/wdog_cfg.sv
`timescale 1ns/1ps
module wdog_cfg
  import wdog_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cfg_we,
  input  wd_cfg_t cfg_in,
  output wd_cfg_t cfg_q,
  output logic    cfg_load
);

  logic locked;

  assign cfg_load = cfg_we && !locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= CFG_RESET;
      locked <= 1'b0;
    end else if (cfg_load) begin
      cfg_q  <= cfg_in;
      locked <= 1'b1;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(cfg_q)); // R6

  AST_CFG_LOCKS: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> locked); // R6

endmodule

// File: rtl/wdog_svc.sv
`timescale 1ns/1ps
module wdog_svc
  import wdog_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              svc_we,
  input  logic [DATA_W-1:0] svc_data,
  input  logic              flush,
  output logic              svc_done
);

  logic armed;
  logic is_first;
  logic is_last;

  assign is_first = (svc_data == DATA_W'(KEY_FIRST));
  assign is_last  = (svc_data == DATA_W'(KEY_LAST));
  assign svc_done = svc_we && is_last && armed && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      armed <= 1'b0;
    end else if (svc_we) begin
      armed <= is_first;
    end
  end

  AST_KEY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (svc_we && !is_first) |=> !armed); // R8

  AST_KEY_ARMS: assert property (@(posedge clk) disable iff (rst)
    (svc_we && is_first && !flush) |=> armed); // R7

endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int SLOW_EXP1 = 5,
  parameter int SLOW_EXP2 = 8,
  parameter int SLOW_EXP3 = 10,
  parameter int FAST_EXP1 = 13,
  parameter int FAST_EXP2 = 16,
  parameter int FAST_EXP3 = 18
) (
  input  logic    clk,
  input  logic    rst,
  input  wd_cfg_t cfg_q,
  input  logic    cfg_load,
  input  logic    slow_tick,
  input  logic    svc_we,
  input  logic    svc_done,
  output logic    early_hit,
  output logic    rst_req
);

  localparam int MAX_EXP = (FAST_EXP3 > SLOW_EXP3) ? FAST_EXP3 : SLOW_EXP3;
  localparam int CNT_W   = MAX_EXP + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] open_at;
  logic             active;
  logic             step;
  logic             win_on;
  logic             tmo;

  always_comb begin
    limit = ONE;
    unique case ({cfg_q.fast, cfg_q.tsel})
      3'b0_01: limit = ONE << SLOW_EXP1;
      3'b0_10: limit = ONE << SLOW_EXP2;
      3'b0_11: limit = ONE << SLOW_EXP3;
      3'b1_01: limit = ONE << FAST_EXP1;
      3'b1_10: limit = ONE << FAST_EXP2;
      3'b1_11: limit = ONE << FAST_EXP3;
      default: limit = ONE;
    endcase
  end

  assign open_at   = limit - (limit >> 2);
  assign active    = (cfg_q.tsel != TSEL_OFF);
  assign step      = active && (cfg_q.fast || slow_tick);
  assign win_on    = active && cfg_q.fast && cfg_q.win;
  assign early_hit = win_on && svc_we && (cnt < open_at);
  assign tmo       = step && (cnt == limit - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (cfg_load) begin
        cnt <= '0;
      end else if (early_hit) begin
        cnt     <= '0;
        rst_req <= 1'b1;
      end else if (svc_done) begin
        cnt <= '0;
      end else if (tmo) begin
        cnt     <= '0;
        rst_req <= 1'b1;
      end else if (step) begin
        cnt <= cnt + ONE;
      end
    end
  end

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.tsel == TSEL_OFF) |=> !rst_req); // R2

  AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (active && !cfg_q.fast && !slow_tick && !svc_we && !cfg_load)
      |=> ($stable(cnt) && !rst_req)); // R3

  AST_FAST_STEP: assert property (@(posedge clk) disable iff (rst)
    (active && cfg_q.fast && !svc_we && !cfg_load && (cnt != limit - ONE))
      |=> (cnt == $past(cnt) + ONE)); // R4

  AST_TMO_PULSE: assert property (@(posedge clk) disable iff (rst)
    (tmo && !svc_we && !cfg_load) |=> (rst_req && cnt == '0)); // R5

  AST_EARLY_FIRE: assert property (@(posedge clk) disable iff (rst)
    (early_hit && !cfg_load) |=> (rst_req && cnt == '0)); // R9

  AST_SVC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (svc_done && !early_hit && !cfg_load) |=> (!rst_req && cnt == '0)); // R7

endmodule

// File: rtl/wdog_window_top.sv
`timescale 1ns/1ps
module wdog_window_top
  import wdog_pkg::*;
#(
  parameter int SLOW_EXP1 = 5,
  parameter int SLOW_EXP2 = 8,
  parameter int SLOW_EXP3 = 10,
  parameter int FAST_EXP1 = 13,
  parameter int FAST_EXP2 = 16,
  parameter int FAST_EXP3 = 18,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_timeout_sel,
  input  logic              cfg_fast_src,
  input  logic              cfg_window_en,
  input  logic              svc_we,
  input  logic [DATA_W-1:0] svc_data,
  output logic              rst_req
);

  wd_cfg_t cfg_in;
  wd_cfg_t cfg_q;
  logic    cfg_load;
  logic    svc_we_g;
  logic    svc_done;
  logic    early_hit;

  assign cfg_in   = '{tsel: cfg_timeout_sel, fast: cfg_fast_src, win: cfg_window_en};
  assign svc_we_g = svc_we && (cfg_q.tsel != TSEL_OFF) && !cfg_load;

  wdog_cfg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_in   (cfg_in),
    .cfg_q    (cfg_q),
    .cfg_load (cfg_load)
  );

  wdog_svc #(.DATA_W(DATA_W)) u_svc (
    .clk      (clk),
    .rst      (rst),
    .svc_we   (svc_we_g),
    .svc_data (svc_data),
    .flush    (early_hit),
    .svc_done (svc_done)
  );

  wdog_counter #(
    .SLOW_EXP1 (SLOW_EXP1),
    .SLOW_EXP2 (SLOW_EXP2),
    .SLOW_EXP3 (SLOW_EXP3),
    .FAST_EXP1 (FAST_EXP1),
    .FAST_EXP2 (FAST_EXP2),
    .FAST_EXP3 (FAST_EXP3)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .cfg_q     (cfg_q),
    .cfg_load  (cfg_load),
    .slow_tick (slow_tick),
    .svc_we    (svc_we_g),
    .svc_done  (svc_done),
    .early_hit (early_hit),
    .rst_req   (rst_req)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !rst_req); // R1

endmodule

// File: tb/wdog_window_top_tb_top.sv
`timescale 1ns/1ps
module wdog_window_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slow_tick = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_timeout_sel = 2'b00;
  logic       cfg_fast_src = 1'b0;
  logic       cfg_window_en = 1'b0;
  logic       svc_we = 1'b0;
  logic [7:0] svc_data = 8'h00;
  logic       rst_req;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  wdog_window_top #(
    .SLOW_EXP1 (2), .SLOW_EXP2 (3), .SLOW_EXP3 (4),
    .FAST_EXP1 (5), .FAST_EXP2 (6), .FAST_EXP3 (7),
    .DATA_W    (8)
  ) dut_i (
    .clk             (clk),
    .rst             (rst),
    .slow_tick       (slow_tick),
    .cfg_we          (cfg_we),
    .cfg_timeout_sel (cfg_timeout_sel),
    .cfg_fast_src    (cfg_fast_src),
    .cfg_window_en   (cfg_window_en),
    .svc_we          (svc_we),
    .svc_data        (svc_data),
    .rst_req         (rst_req)
  );

  task automatic chk(input logic exp, input string tag);
    n_chk++;
    if (rst_req !== exp) begin
      n_bad++;
      $display("FAIL %s: rst_req got %0b expected %0b at %0t", tag, rst_req, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] sel, input logic fast, input logic win);
    cfg_we = 1'b1; cfg_timeout_sel = sel; cfg_fast_src = fast; cfg_window_en = win;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic svc(input logic [7:0] d);
    svc_we = 1'b1; svc_data = d;
    step(1);
    svc_we = 1'b0;
  endtask

  task automatic tick();
    slow_tick = 1'b1;
    step(1);
    slow_tick = 1'b0;
  endtask

  task automatic t_reset_default();
    do_reset();
    chk(1'b0, "R1 idle after reset");
    step(100);
    chk(1'b0, "R3 no count without slow_tick");
    repeat (15) tick();
    chk(1'b0, "R1 default one tick short");
    tick();
    chk(1'b1, "R1 default 16-tick timeout");
    step(1);
    chk(1'b0, "R5 pulse one cycle");
  endtask

  task automatic t_fast_timeouts();
    do_reset();
    cfg(2'b01, 1'b1, 1'b0);
    step(31);
    chk(1'b0, "R4 sel01 one short");
    step(1);
    chk(1'b1, "R4 sel01 timeout 32");
    step(1);
    chk(1'b0, "R5 pulse ends");
    step(30);
    chk(1'b0, "R5 restart one short");
    step(1);
    chk(1'b1, "R5 restarted period");
    do_reset();
    cfg(2'b11, 1'b1, 1'b0);
    step(127);
    chk(1'b0, "R4 sel11 one short");
    step(1);
    chk(1'b1, "R4 sel11 timeout 128");
  endtask

  task automatic t_write_once();
    do_reset();
    cfg(2'b01, 1'b1, 1'b0);
    cfg(2'b00, 1'b1, 1'b0);
    step(30);
    chk(1'b0, "R6 second write ignored, one short");
    step(1);
    chk(1'b1, "R6 first config still in force");
  endtask

  task automatic t_service();
    do_reset();
    cfg(2'b10, 1'b1, 1'b0);
    step(50);
    svc(8'h55);
    svc(8'hAA);
    step(63);
    chk(1'b0, "R7 key cleared count past old deadline");
    step(1);
    chk(1'b1, "R7 timeout 64 after key");
  endtask

  task automatic t_broken_key();
    do_reset();
    cfg(2'b01, 1'b1, 1'b0);
    step(10);
    svc(8'h55);
    svc(8'h12);
    svc(8'hAA);
    step(18);
    chk(1'b0, "R8 one short of original deadline");
    step(1);
    chk(1'b1, "R8 broken key did not clear");
  endtask

  task automatic t_window_early();
    do_reset();
    cfg(2'b01, 1'b1, 1'b1);
    step(23);
    svc(8'h55);
    chk(1'b1, "R9 write at count 23 is early");
    step(1);
    chk(1'b0, "R9 pulse one cycle");
    step(30);
    chk(1'b0, "R9 restart one short");
    step(1);
    chk(1'b1, "R9 count restarted by early write");
  endtask

  task automatic t_window_late();
    do_reset();
    cfg(2'b01, 1'b1, 1'b1);
    step(24);
    svc(8'h55);
    chk(1'b0, "R10 write at threshold accepted");
    svc(8'hAA);
    chk(1'b0, "R10 key completes in window");
    step(31);
    chk(1'b0, "R10 cleared, one short");
    step(1);
    chk(1'b1, "R10 new period after key");
  endtask

  task automatic t_slow_window();
    do_reset();
    cfg(2'b01, 1'b0, 1'b1);
    tick();
    tick();
    svc(8'h55);
    chk(1'b0, "R11 no window on slow source");
    svc(8'hAA);
    chk(1'b0, "R11 key accepted early");
    repeat (3) tick();
    chk(1'b0, "R11 cleared, one tick short");
    tick();
    chk(1'b1, "R3 sel01 slow timeout 4 ticks");
  endtask

  task automatic t_disabled();
    bit seen;
    do_reset();
    cfg(2'b00, 1'b1, 1'b1);
    seen = 1'b0;
    svc(8'hAA);
    if (rst_req) seen = 1'b1;
    svc(8'h55);
    if (rst_req) seen = 1'b1;
    for (int i = 0; i < 300; i++) begin
      step(1);
      if (rst_req) seen = 1'b1;
    end
    n_chk++;
    if (seen) begin
      n_bad++;
      $display("FAIL R2: rst_req got 1 expected 0 while disabled");
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, got no end expected end");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_default();
    t_fast_timeouts();
    t_write_once();
    t_service();
    t_broken_key();
    t_window_early();
    t_window_late();
    t_slow_window();
    t_disabled();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule